// File: doc/BRIEF.md
# Bulk Data Phase Packet Framer

This block runs the data phase of a serial bulk transfer, after the command phase for a long write or long read has already gone out on the link. It stands between a byte stream on the host side and a byte stream on the link side, and it adds or removes the framing bytes around the payload.

On a write, the framer splits the requested length into packets. Each packet starts with a marker byte whose low two bits give the packet's position in the transfer. The payload follows, then, when the check field is on, a fixed number of filler check bytes. The framer does not wait for any reply between packets. On a read, the first chunk's payload starts at once, because the command phase has already found the first marker. Before every later chunk, the framer discards link bytes until a marker byte turns up, and it gives up after a bounded number of tries. It drops the check bytes that follow each chunk. A request that is too short is refused before any byte moves.

Top module: `dpf_framer`

## Requirements
- R1: A start with a length of 4 or less moves no byte in either direction. It ends with `done` and `err` both set, one cycle after the start is taken.
- R2: Each write packet begins with a marker byte whose upper nibble is 0xF and whose bits 3:2 are zero. Bits 1:0 are 3 when the remaining length fits in one packet, 1 for the first packet of a longer transfer, and 2 for any later packet that is not final.
- R3: A packet's payload is at most PKT_MAX bytes (8192 by default). Every packet except the last is full, and the last one carries the residual count.
- R4: With `crc_on` set, each write packet's payload is followed by CRC_BYTES (2) bytes of value 0x00. With `crc_on` clear, no such bytes are sent. In both cases the next marker follows at once.
- R5: Write payload bytes pass to `tx_data` unchanged and in order. `in_ready` is high only while a payload byte is being sent and `tx_ready` is high, and exactly `xfer_len` host bytes are taken.
- R6: A read passes link bytes to `out_data` from the first byte after the start, with no marker search before the first chunk.
- R7: Before each later read chunk, the framer consumes link bytes until one has an upper nibble of 0xF. Up to 11 bytes are tried (a marker in the 11th position is accepted). Neither the rejected bytes nor the marker reach `out_data`.
- R8: When 11 bytes in a row fail the marker test, the framer raises `done` with `err` and consumes no further link bytes.
- R9: With `crc_on` set, CRC_BYTES link bytes after each read chunk are consumed and discarded. With `crc_on` clear, the next chunk's search starts right after the payload.
- R10: After reset, and again after the cycle with `done`, the block is idle: `busy`, `done` and all valid/ready outputs are low. `done` lasts one cycle. `err` is valid with `done`, holds until the next start, and is cleared by that start.
- R11: A `start` pulse seen while `busy` is high is ignored, and the transfer in progress is unaffected.
- R12: While `tx_valid` or `out_valid` is high and its ready is low, the valid stays high and the data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir_rd | input | 1 | 1 = read data phase, 0 = write data phase |
| crc_on | input | 1 | Check bytes present after each packet |
| xfer_len | input | LEN_W (24) | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Transfer refused or marker search failed |
| in_valid | input | 1 | Host write byte valid |
| in_data | input | 8 | Host write byte |
| in_ready | output | 1 | Host write byte taken |
| tx_valid | output | 1 | Link transmit byte valid |
| tx_data | output | 8 | Link transmit byte |
| tx_ready | input | 1 | Link accepts transmit byte |
| rx_valid | input | 1 | Link receive byte valid |
| rx_data | input | 8 | Link receive byte |
| rx_ready | output | 1 | Receive byte consumed |
| out_valid | output | 1 | Host read byte valid |
| out_data | output | 8 | Host read byte |
| out_ready | input | 1 | Host accepts read byte |

## Verification
The hold checks on `tx_data` and `out_data` assume the source side behaves as a well-formed stream. Once `in_valid` or `rx_valid` is raised, it stays up with the same byte until the framer takes it, because in the payload states the framer forwards those inputs without a register. The bench keeps to this by driving each byte from a pointer that advances only on an observed handshake. It also throttles `tx_ready` and `out_ready` in a fixed pattern, so that every stall path is exercised while the sources hold still.

// File: rtl/dpf_pkg.sv
`timescale 1ns/1ps
package dpf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_WHDR, ST_WPAY, ST_WCRC,
      ST_RHUNT, ST_RPAY, ST_RCRC, ST_FIN
   } dpf_state_t;

   localparam logic [3:0] HDR_TAG   = 4'hF;
   localparam logic [1:0] ORD_FIRST = 2'd1;
   localparam logic [1:0] ORD_MID   = 2'd2;
   localparam logic [1:0] ORD_ONLY  = 2'd3;
endpackage

// File: rtl/dpf_count.sv
`timescale 1ns/1ps
// Remaining-byte and in-packet counters with packet-size clipping.
module dpf_count #(
   parameter int LEN_W   = 24,
   parameter int PKT_MAX = 8192,
   parameter int PKT_W   = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_total,
   input  logic [LEN_W-1:0] total,
   input  logic             load_pkt,
   input  logic             dec,
   output logic             fits,
   output logic             pkt_last,
   output logic             rem_last,
   output logic             rem_zero
);
   logic [LEN_W-1:0] rem_q;
   logic [PKT_W-1:0] pkt_q;

   function automatic logic [PKT_W-1:0] clip(input logic [LEN_W-1:0] v);
      if (v <= LEN_W'(PKT_MAX)) clip = v[PKT_W-1:0];
      else                      clip = PKT_W'(PKT_MAX);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         pkt_q <= '0;
      end else if (load_total) begin
         rem_q <= total;
         pkt_q <= clip(total);
      end else begin
         if (load_pkt) pkt_q <= clip(rem_q);
         if (dec) begin
            rem_q <= rem_q - 1'b1;
            pkt_q <= pkt_q - 1'b1;
         end
      end
   end

   assign fits     = (rem_q <= LEN_W'(PKT_MAX));
   assign pkt_last = (pkt_q == PKT_W'(1));
   assign rem_last = (rem_q == LEN_W'(1));
   assign rem_zero = (rem_q == '0);
endmodule

// File: rtl/dpf_hunt.sv
`timescale 1ns/1ps
// Bounded search for a read chunk marker byte.
module dpf_hunt #(
   parameter int TRIES = 11,
   parameter int TRY_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       probe,
   input  logic [3:0] tag,
   output logic       hit,
   output logic       give_up
);
   logic [TRY_W-1:0] miss_q;

   assign hit     = (tag == dpf_pkg::HDR_TAG);
   assign give_up = probe && !hit && (miss_q == TRY_W'(TRIES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)              miss_q <= '0;
      else if (clr)            miss_q <= '0;
      else if (probe && !hit)  miss_q <= miss_q + 1'b1;
   end
endmodule

// File: rtl/dpf_framer.sv
`timescale 1ns/1ps
module dpf_framer #(
   parameter int LEN_W      = 24,
   parameter int PKT_MAX    = 8192,
   parameter int CRC_BYTES  = 2,
   parameter int TRIES      = 11,
   parameter int MIN_LEN    = 4,
   parameter bit HUNT_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             dir_rd,
   input  logic             crc_on,
   input  logic [LEN_W-1:0] xfer_len,
   output logic             busy,
   output logic             done,
   output logic             err,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   input  logic             tx_ready,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             rx_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready
);
   import dpf_pkg::*;

   localparam int PKT_W = $clog2(PKT_MAX + 1);
   localparam int TRY_W = $clog2(TRIES + 1);
   localparam int CRC_W = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;

   initial begin
      if (PKT_MAX < 1 || LEN_W < PKT_W || TRIES < 1 || CRC_BYTES < 1 || MIN_LEN < 0)
         $error("dpf_framer: parameter set out of range");
   end

   dpf_state_t state_q, state_d, rd_entry;
   logic [CRC_W-1:0] crc_idx_q;
   logic crc_q, first_q, err_q;
   logic ld_total, ld_pkt, dec, hunt_clr, probe, crc_step, set_err, take;
   logic fits, pkt_last, rem_last, rem_zero, hit, give_up, crc_last;
   logic [1:0] order;

   generate
      if (HUNT_FIRST) begin : g_hunt_first
         assign rd_entry = ST_RHUNT;
      end else begin : g_direct_first
         assign rd_entry = ST_RPAY;
      end
   endgenerate

   dpf_count #(.LEN_W(LEN_W), .PKT_MAX(PKT_MAX), .PKT_W(PKT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load_total(ld_total), .total(xfer_len),
      .load_pkt(ld_pkt), .dec(dec), .fits(fits), .pkt_last(pkt_last),
      .rem_last(rem_last), .rem_zero(rem_zero)
   );

   dpf_hunt #(.TRIES(TRIES), .TRY_W(TRY_W)) u_hunt (
      .clk(clk), .rst_n(rst_n), .clr(hunt_clr), .probe(probe),
      .tag(rx_data[7:4]), .hit(hit), .give_up(give_up)
   );

   assign crc_last = (crc_idx_q == CRC_W'(CRC_BYTES - 1));
   assign order    = fits ? ORD_ONLY : (first_q ? ORD_FIRST : ORD_MID);
   assign take     = (state_q == ST_IDLE) && start;

   always_comb begin
      state_d   = state_q;
      tx_valid  = 1'b0;
      tx_data   = 8'h00;
      in_ready  = 1'b0;
      rx_ready  = 1'b0;
      out_valid = 1'b0;
      out_data  = 8'h00;
      ld_total  = 1'b0;
      ld_pkt    = 1'b0;
      dec       = 1'b0;
      hunt_clr  = 1'b0;
      probe     = 1'b0;
      crc_step  = 1'b0;
      set_err   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start) begin
            ld_total = 1'b1;
            hunt_clr = 1'b1;
            if (xfer_len <= LEN_W'(MIN_LEN)) begin
               set_err = 1'b1;
               state_d = ST_FIN;
            end else begin
               state_d = dir_rd ? rd_entry : ST_WHDR;
            end
         end
         ST_WHDR: begin
            tx_valid = 1'b1;
            tx_data  = {HDR_TAG, 2'b00, order};
            if (tx_ready) begin
               ld_pkt  = 1'b1;
               state_d = ST_WPAY;
            end
         end
         ST_WPAY: begin
            tx_valid = in_valid;
            tx_data  = in_data;
            in_ready = tx_ready;
            if (in_valid && tx_ready) begin
               dec = 1'b1;
               if (pkt_last)
                  state_d = crc_q ? ST_WCRC : (rem_last ? ST_FIN : ST_WHDR);
            end
         end
         ST_WCRC: begin
            tx_valid = 1'b1;
            if (tx_ready) begin
               crc_step = 1'b1;
               if (crc_last) state_d = rem_zero ? ST_FIN : ST_WHDR;
            end
         end
         ST_RHUNT: begin
            rx_ready = 1'b1;
            if (rx_valid) begin
               probe = 1'b1;
               if (hit) begin
                  ld_pkt   = 1'b1;
                  hunt_clr = 1'b1;
                  state_d  = ST_RPAY;
               end else if (give_up) begin
                  set_err = 1'b1;
                  state_d = ST_FIN;
               end
            end
         end
         ST_RPAY: begin
            out_valid = rx_valid;
            out_data  = rx_data;
            rx_ready  = out_ready;
            if (rx_valid && out_ready) begin
               dec = 1'b1;
               if (pkt_last)
                  state_d = crc_q ? ST_RCRC : (rem_last ? ST_FIN : ST_RHUNT);
            end
         end
         ST_RCRC: begin
            rx_ready = 1'b1;
            if (rx_valid) begin
               crc_step = 1'b1;
               if (crc_last) state_d = rem_zero ? ST_FIN : ST_RHUNT;
            end
         end
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         crc_idx_q <= '0;
         crc_q     <= 1'b0;
         first_q   <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (take) begin
            crc_q     <= crc_on;
            first_q   <= 1'b1;
            crc_idx_q <= '0;
         end else begin
            if (state_q == ST_WHDR && tx_ready) first_q <= 1'b0;
            if (crc_step) crc_idx_q <= crc_last ? '0 : crc_idx_q + 1'b1;
         end
         if (set_err)   err_q <= 1'b1;
         else if (take) err_q <= 1'b0;
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_FIN);
   assign err  = err_q;
endmodule

// File: rtl/dpf_framer_chk.sv
`timescale 1ns/1ps
module dpf_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic       in_valid,
   input logic [7:0] in_data,
   input logic       in_ready,
   input logic       tx_valid,
   input logic [7:0] tx_data,
   input logic       tx_ready,
   input logic       out_valid,
   input logic [7:0] out_data,
   input logic       out_ready
);
   // R12
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   // R12
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R5
   pay_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> tx_valid && tx_ready && (tx_data == in_data));

   // R5
   dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);

   // R10
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);
endmodule

bind dpf_framer dpf_framer_chk u_chk (.*);

// File: tb/sim_dpf_framer.sv
`timescale 1ns/1ps
module sim_dpf_framer;
   localparam int PKT = 8192;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, dir_rd = 1'b0, crc_on = 1'b0;
   logic [23:0] xfer_len = '0;
   logic busy, done, err;
   logic in_valid = 1'b0; logic [7:0] in_data = '0; logic in_ready;
   logic tx_valid; logic [7:0] tx_data; logic tx_ready = 1'b0;
   logic rx_valid = 1'b0; logic [7:0] rx_data = '0; logic rx_ready;
   logic out_valid; logic [7:0] out_data; logic out_ready = 1'b0;
   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   dpf_framer u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .crc_on(crc_on),
      .xfer_len(xfer_len), .busy(busy), .done(done), .err(err),
      .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   function automatic byte unsigned pat(input int i);
      return 8'(i * 13 + (i >> 8) + 5);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(!busy && !done && !err, "R10 reset idle", {busy, done, err}, 0);
      chk(!tx_valid && !in_ready && !rx_ready && !out_valid, "R10 reset streams",
          {tx_valid, in_ready, rx_ready, out_valid}, 0);
   endtask

   // Write data phase; poke pulses a second start mid-transfer.
   task automatic t_write(input int len, input bit crc, input bit poke);
      byte unsigned exp_q[$];
      byte unsigned got_q[$];
      int hdr_pos[$];
      int idx = 0;
      bit fin = 0;
      bit e = 0;
      if (len > 4) begin
         int rem = len;
         bit first = 1;
         int k = 0;
         while (rem > 0) begin
            int n = (rem > PKT) ? PKT : rem;
            hdr_pos.push_back(exp_q.size());
            exp_q.push_back(8'hF0 | ((rem <= PKT) ? 8'd3 : (first ? 8'd1 : 8'd2)));
            for (int j = 0; j < n; j++) begin exp_q.push_back(pat(k)); k++; end
            if (crc) begin exp_q.push_back(8'h00); exp_q.push_back(8'h00); end
            rem -= n;
            first = 0;
         end
      end
      @(negedge clk);
      start = 1'b1; dir_rd = 1'b0; crc_on = crc; xfer_len = 24'(len);
      for (int cyc = 0; cyc < 60000 && !fin; cyc++) begin
         @(negedge clk);
         start = poke && (cyc == 40);
         if (poke && cyc == 40) begin dir_rd = 1'b1; xfer_len = 24'd6; end
         in_valid = (idx < len);
         in_data  = pat(idx);
         tx_ready = (cyc % 3) != 2;
         #1;
         if (tx_valid && tx_ready) got_q.push_back(tx_data);
         if (in_valid && in_ready) idx++;
         if (done) begin fin = 1; e = err; end
      end
      start = 1'b0; in_valid = 1'b0; tx_ready = 1'b0;
      chk(fin, "R10 write done seen", fin, 1);
      chk(e == (len <= 4), "R1 R10 write err flag", e, (len <= 4));
      chk(got_q.size() == exp_q.size(), "R3 R4 write byte count", got_q.size(), exp_q.size());
      chk(idx == ((len > 4) ? len : 0), "R5 R1 host bytes taken", idx, (len > 4) ? len : 0);
      foreach (hdr_pos[h]) begin
         int p = hdr_pos[h];
         int a = (p < got_q.size()) ? int'(got_q[p]) : -1;
         chk(a == int'(exp_q[p]), "R2 packet marker", a, exp_q[p]);
      end
      begin
         int mis = -1;
         for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (mis < 0 && got_q[i] != exp_q[i]) mis = i;
         chk(mis < 0, poke ? "R11 R5 R4 stream under second start" : "R5 R4 write stream",
             (mis < 0) ? 0 : int'(got_q[mis]), (mis < 0) ? 0 : int'(exp_q[mis]));
      end
   endtask

   // Read data phase; fail makes the second marker search run dry.
   task automatic t_read(input int len, input bit crc, input bit fail);
      byte unsigned rx_q[$];
      byte unsigned exp_q[$];
      byte unsigned got_q[$];
      int need;
      int ptr = 0;
      bit fin = 0;
      bit e = 0;
      if (len > 4) begin
         int rem = len;
         int k = 0;
         int hunt = 0;
         bool_loop: while (rem > 0) begin
            int n = (rem > PKT) ? PKT : rem;
            if (k > 0) begin
               int junk = fail ? 11 : ((hunt % 2 == 0) ? 0 : 10);
               for (int j = 0; j < junk; j++) rx_q.push_back(8'h30 + 8'(j));
               if (fail) break;
               rx_q.push_back(8'hF0 | 8'(hunt + 1));
               hunt++;
            end
            for (int j = 0; j < n; j++) begin
               rx_q.push_back(pat(k)); exp_q.push_back(pat(k)); k++;
            end
            if (crc) begin rx_q.push_back(8'hC7); rx_q.push_back(8'hE1); end
            rem -= n;
         end
      end
      need = rx_q.size();
      rx_q.push_back(8'hF5); rx_q.push_back(8'h11); rx_q.push_back(8'h22);
      @(negedge clk);
      start = 1'b1; dir_rd = 1'b1; crc_on = crc; xfer_len = 24'(len);
      for (int cyc = 0; cyc < 60000 && !fin; cyc++) begin
         @(negedge clk);
         start = 1'b0;
         rx_valid  = 1'b1;
         rx_data   = rx_q[ptr];
         out_ready = (cyc % 4) != 1;
         #1;
         if (out_valid && out_ready) got_q.push_back(out_data);
         if (rx_valid && rx_ready) ptr++;
         if (done) begin fin = 1; e = err; end
      end
      rx_valid = 1'b0; out_ready = 1'b0;
      chk(fin, "R10 read done seen", fin, 1);
      chk(e == (fail || len <= 4), fail ? "R8 hunt exhausted err" : "R1 R10 read err flag",
          e, (fail || len <= 4));
      chk(ptr == need, fail ? "R8 link bytes consumed" : "R7 R9 link bytes consumed", ptr, need);
      chk(got_q.size() == exp_q.size(), "R6 R7 read byte count", got_q.size(), exp_q.size());
      begin
         int mis = -1;
         for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            if (mis < 0 && got_q[i] != exp_q[i]) mis = i;
         chk(mis < 0, "R6 R7 R9 read payload",
             (mis < 0) ? 0 : int'(got_q[mis]), (mis < 0) ? 0 : int'(exp_q[mis]));
      end
      @(negedge clk); #1;
      chk(!busy && !done, "R10 idle after done", {busy, done}, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_write(4, 1'b1, 1'b0);             // R1 refused write
      t_read(0, 1'b0, 1'b0);              // R1 refused read
      t_write(5, 1'b1, 1'b0);             // R2 single packet, R4 zeros
      t_write(2 * PKT + 3, 1'b1, 1'b1);   // R2 R3 first/middle/last, R11 poke
      t_write(PKT + 1, 1'b0, 1'b0);       // R3 residual of one, R4 no check bytes
      t_read(2 * PKT + 7, 1'b1, 1'b0);    // R7 hunts of 0 and 10 junk, R9
      t_read(PKT + 9, 1'b0, 1'b1);        // R8 eleven misses
      t_read(9, 1'b0, 1'b0);              // R6, R10 err cleared by new start
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule